// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Guarded 80-bit Accumulator

This block multiplies two signed Q1.31 fractional operands and folds the product into an 80-bit accumulator. On every clock edge a two-bit operation code selects one of four actions:

- keep the accumulator as it is;
- zero it;
- add the product;
- subtract the product.

The accumulator has three fields. The top 16 bits are guard bits, so intermediate sums can grow past ±1.0 without wrapping. The middle 32 bits form the result word in ordinary Q1.31 form. The bottom 32 bits hold the low-order part of each product, so very small terms are kept.

A filter loop issues a clear and then a run of multiply-add or multiply-subtract cycles. At the end it reads the middle word. An overflow flag shows when the accumulated value no longer fits a Q1.31 word. When the flag is set, a saturation enable clamps the readout to the nearest full-scale code.

The operation code is the block's only state selector:

- HOLD (00) is the idle transition, back to the same accumulator value.
- CLR (01) moves to the zero state.
- MAC (10) moves to acc + P.
- MSUB (11) moves to acc − P.

Top module: `xacc_mac`

## Requirements
- R1: While rst_n is low, acc_o is all zero, ovf_o is 0 and result_o is 0.
- R2: With op_i = 00 (HOLD) the accumulator keeps its value on the next edge, whatever a_i and b_i carry.
- R3: With op_i = 01 (CLR) all 80 accumulator bits are zero after the next edge.
- R4: With op_i = 10 (MAC) the accumulator becomes acc + P after the next edge, modulo 2^80. P is the signed 64-bit product a_i × b_i, sign-extended to 80 bits and shifted left by one.
- R5: With op_i = 11 (MSUB) the accumulator becomes acc − P after the next edge, modulo 2^80.
- R6: Starting from zero, MAC with a_i = b_i = 0x80000000 (−1 × −1) gives 0x0000_8000_0000_0000_0000, which is +1.0 and does not wrap.
- R7: guard_o is acc bits 79:64, low_o is bits 31:0, and with sat_en_i = 0 result_o is bits 63:32.
- R8: ovf_o is 1 exactly when acc bits 79:63 are not all equal.
- R9: With sat_en_i = 1 and ovf_o = 1, result_o is 0x7FFFFFFF when acc bit 79 is 0 and 0x80000000 when it is 1. With sat_en_i = 1 and ovf_o = 0, result_o is bits 63:32.
- R10: After CLR, MSUB of −1 × −1 gives −1.0 (0xFFFF_8000_0000_0000_0000, ovf_o = 0). A second such MSUB gives −2.0 (0xFFFF_0000_0000_0000_0000, guard field 0xFFFF, ovf_o = 1).
- R11: The product of the smallest codes, 0x00000001 × 0x00000001, lands in the low field (low_o = 2) and leaves the result word at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2 | Operation: 00 HOLD, 01 CLR, 10 MAC, 11 MSUB |
| a_i | input | 32 | Q1.31 multiplicand |
| b_i | input | 32 | Q1.31 multiplier |
| sat_en_i | input | 1 | Clamp result_o on overflow |
| acc_o | output | 80 | Full accumulator |
| guard_o | output | 16 | Overflow guard field, bits 79:64 |
| result_o | output | 32 | Result word, bits 63:32, raw or saturated |
| low_o | output | 32 | Low-order field, bits 31:0 |
| ovf_o | output | 1 | Value outside the Q1.31 range |

## Verification
The bench targets several corner cases:

- **−1 × −1.** A design that shifts the 64-bit product before sign-extending it turns +1.0 into −1.0.
- **Two successive subtractions of that product.** These must reach −2.0 with the guard field all ones. A design that truncates the guard field, or forgets to sign-extend, leaves zeros up there or wraps positive.
- **The smallest-code product.** This exposes a missing alignment shift, which would leave low_o at 1 instead of 2.
- **Saturation on both signs.** A wrong sign bit would clamp to the opposite full-scale code.
- **HOLD with live operands.** A design that ignored the operation code would still accumulate.

Around these directed cases, seeded random operation streams with frequent full-scale operands are checked against an 80-bit reference model.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

    localparam int WORD_W  = 32;
    localparam int GUARD_W = 16;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_CLR  = 2'b01,
        OP_MAC  = 2'b10,
        OP_MSUB = 2'b11
    } acc_op_e;

endpackage

// File: rtl/xacc_mul.sv
module xacc_mul #(
    parameter int WORD_W  = 32,
    parameter int GUARD_W = 16,
    localparam int PROD_W = 2 * WORD_W,
    localparam int ACC_W  = GUARD_W + PROD_W
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [ACC_W-1:0]  prod_o
);

    logic signed [PROD_W-1:0] full_prod;
    logic        [ACC_W-1:0]  wide_prod;

    // Signed integer product of the two Q1.31 codes.
    assign full_prod = $signed(a_i) * $signed(b_i);

    // Widen before the alignment shift so that -1 x -1 stays positive.
    assign wide_prod = {{GUARD_W{full_prod[PROD_W-1]}}, full_prod};

    // Fractional alignment: drop the duplicate sign bit.
    assign prod_o = {wide_prod[ACC_W-2:0], 1'b0};

endmodule

// File: rtl/xacc_core.sv
module xacc_core
    import xacc_pkg::*;
#(
    parameter int ACC_W = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_op_e          op_i,
    input  logic [ACC_W-1:0] prod_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;

    // Next-value selection.
    always_comb begin
        unique case (op_i)
            OP_HOLD: acc_d = acc_q;
            OP_CLR:  acc_d = '0;
            OP_MAC:  acc_d = acc_q + prod_i;
            OP_MSUB: acc_d = acc_q - prod_i;
        endcase
    end

    // Accumulator register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 || !rst_n));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_HOLD |=> $stable(acc_q));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLR |=> acc_q == '0);

    p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MAC |=> acc_q == $past(acc_q) + $past(prod_i));

    p_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_MSUB |=> acc_q == $past(acc_q) - $past(prod_i));

endmodule

// File: rtl/xacc_readout.sv
module xacc_readout #(
    parameter int WORD_W  = 32,
    parameter int GUARD_W = 16,
    localparam int ACC_W  = GUARD_W + 2 * WORD_W,
    localparam int TOP_LO = 2 * WORD_W - 1
) (
    input  logic [ACC_W-1:0]   acc_i,
    input  logic               sat_en_i,
    output logic [GUARD_W-1:0] guard_o,
    output logic [WORD_W-1:0]  result_o,
    output logic [WORD_W-1:0]  low_o,
    output logic               ovf_o
);

    localparam logic [WORD_W-1:0] POS_FULL = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] NEG_FULL = {1'b1, {(WORD_W-1){1'b0}}};

    logic [ACC_W-1:TOP_LO] top_bits;
    logic [WORD_W-1:0]     mid_word;

    assign top_bits = acc_i[ACC_W-1:TOP_LO];
    assign mid_word = acc_i[TOP_LO:WORD_W];
    assign guard_o  = acc_i[ACC_W-1:2*WORD_W];
    assign low_o    = acc_i[WORD_W-1:0];

    // Out of range when the guard bits and the word sign disagree.
    assign ovf_o = !((&top_bits) || !(|top_bits));

    always_comb begin
        if (sat_en_i && ovf_o)
            result_o = acc_i[ACC_W-1] ? NEG_FULL : POS_FULL;
        else
            result_o = mid_word;
    end

endmodule

// File: rtl/xacc_mac.sv
module xacc_mac
    import xacc_pkg::*;
#(
    parameter int WORD_W  = xacc_pkg::WORD_W,
    parameter int GUARD_W = xacc_pkg::GUARD_W,
    localparam int ACC_W  = GUARD_W + 2 * WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         op_i,
    input  logic [WORD_W-1:0]  a_i,
    input  logic [WORD_W-1:0]  b_i,
    input  logic               sat_en_i,
    output logic [ACC_W-1:0]   acc_o,
    output logic [GUARD_W-1:0] guard_o,
    output logic [WORD_W-1:0]  result_o,
    output logic [WORD_W-1:0]  low_o,
    output logic               ovf_o
);

    acc_op_e          op;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] acc;

    assign op = acc_op_e'(op_i);

    xacc_mul #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod)
    );

    xacc_core #(.ACC_W(ACC_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .prod_i (prod),
        .acc_o  (acc)
    );

    xacc_readout #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_read (
        .acc_i    (acc),
        .sat_en_i (sat_en_i),
        .guard_o  (guard_o),
        .result_o (result_o),
        .low_o    (low_o),
        .ovf_o    (ovf_o)
    );

    assign acc_o = acc;

    p_sat_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en_i && ovf_o && !acc[ACC_W-1]) |->
            result_o == {1'b0, {(WORD_W-1){1'b1}}});

    p_sat_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en_i && ovf_o && acc[ACC_W-1]) |->
            result_o == {1'b1, {(WORD_W-1){1'b0}}});

    p_in_range_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_o |-> result_o == acc[2*WORD_W-1:WORD_W]);

    p_plus_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLR) ##1 (op == OP_MAC && a_i == {1'b1, {(WORD_W-1){1'b0}}}
                            && b_i == {1'b1, {(WORD_W-1){1'b0}}})
        |=> ovf_o && !acc[ACC_W-1]);

endmodule

// File: tb/tb_xacc_mac.sv
module tb_xacc_mac;

    localparam int DW = 32;
    localparam int GW = 16;
    localparam int AW = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [DW-1:0] a_i = '0;
    logic [DW-1:0] b_i = '0;
    logic          sat_en_i = 1'b0;
    logic [AW-1:0] acc_o;
    logic [GW-1:0] guard_o;
    logic [DW-1:0] result_o;
    logic [DW-1:0] low_o;
    logic          ovf_o;

    int errs = 0;
    int checks = 0;
    logic [AW-1:0] m_acc = '0;

    xacc_mac dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .sat_en_i(sat_en_i), .acc_o(acc_o), .guard_o(guard_o),
        .result_o(result_o), .low_o(low_o), .ovf_o(ovf_o)
    );

    always #10 clk = ~clk;

    function automatic logic [AW-1:0] ref_prod(logic [DW-1:0] a, logic [DW-1:0] b);
        logic [AW-1:0] ea;
        logic [AW-1:0] eb;
        logic [AW-1:0] p;
        ea = {{(AW-DW){a[DW-1]}}, a};
        eb = {{(AW-DW){b[DW-1]}}, b};
        p  = ea * eb;
        return p << 1;
    endfunction

    function automatic logic ref_ovf(logic [AW-1:0] v);
        return !(v[79:63] == '0 || v[79:63] == '1);
    endfunction

    function automatic logic [DW-1:0] ref_word(logic [AW-1:0] v, logic sat);
        if (sat && ref_ovf(v)) return v[79] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return v[63:32];
    endfunction

    task automatic chk80(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s acc actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk32(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s word actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s flag actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, compare.
    task automatic step(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b,
                        logic sat, string tag);
        op_i = op; a_i = a; b_i = b; sat_en_i = sat;
        case (op)
            2'b01:   m_acc = '0;
            2'b10:   m_acc = m_acc + ref_prod(a, b);
            2'b11:   m_acc = m_acc - ref_prod(a, b);
            default: m_acc = m_acc;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk80(tag, acc_o, m_acc);
        chk1("R8", ovf_o, ref_ovf(m_acc));
        chk32(sat ? "R9" : "R7", result_o, ref_word(m_acc, sat));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk80("R1", acc_o, '0);
        chk1("R1", ovf_o, 1'b0);
        chk32("R1", result_o, '0);
        rst_n = 1'b1;

        step(2'b10, 32'h4000_0000, 32'h2000_0000, 1'b0, "R4");
        step(2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R4");
        step(2'b11, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R5");
        // R2: hold with live operands
        step(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, "R2");
        step(2'b01, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, "R3");
        chk80("R3", acc_o, '0);

        // R6: -1 x -1 is +1.0
        step(2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0, "R6");
        chk80("R6", acc_o, 80'h0000_8000_0000_0000_0000);
        chk1("R6", ovf_o, 1'b1);
        step(2'b00, 32'h0, 32'h0, 1'b1, "R9");
        chk32("R9", result_o, 32'h7FFF_FFFF);

        // R10: subtract twice to reach -2.0
        step(2'b01, 32'h0, 32'h0, 1'b0, "R3");
        step(2'b11, 32'h8000_0000, 32'h8000_0000, 1'b0, "R10");
        chk80("R10", acc_o, 80'hFFFF_8000_0000_0000_0000);
        chk1("R10", ovf_o, 1'b0);
        chk32("R10", result_o, 32'h8000_0000);
        step(2'b11, 32'h8000_0000, 32'h8000_0000, 1'b1, "R10");
        chk80("R10", acc_o, 80'hFFFF_0000_0000_0000_0000);
        chk32("R10", {16'h0, guard_o}, 32'h0000_FFFF);
        chk1("R10", ovf_o, 1'b1);
        chk32("R9", result_o, 32'h8000_0000);

        // R11: smallest product stays in the low field
        step(2'b01, 32'h0, 32'h0, 1'b0, "R3");
        step(2'b10, 32'h0000_0001, 32'h0000_0001, 1'b0, "R11");
        chk32("R11", low_o, 32'h0000_0002);
        chk32("R11", result_o, 32'h0);
        chk32("R7", {16'h0, guard_o}, 32'h0);

        // Random stream with frequent full-scale operands
        for (int i = 0; i < 400; i++) begin
            logic [1:0]    op;
            logic [DW-1:0] a;
            logic [DW-1:0] b;
            int            pick;
            pick = int'($urandom_range(0, 15));
            op   = (pick == 0) ? 2'b01 : (pick < 3) ? 2'b00 :
                   (pick < 10) ? 2'b10 : 2'b11;
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 3) == 0) a = $urandom_range(0, 1) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            if ($urandom_range(0, 3) == 0) b = $urandom_range(0, 1) ? 32'h8000_0000 : 32'h7FFF_FFFF;
            case (op)
                2'b00:   step(op, a, b, 1'($urandom_range(0, 1)), "R2");
                2'b01:   step(op, a, b, 1'($urandom_range(0, 1)), "R3");
                2'b10:   step(op, a, b, 1'($urandom_range(0, 1)), "R4");
                default: step(op, a, b, 1'($urandom_range(0, 1)), "R5");
            endcase
            chk32("R7", low_o, m_acc[31:0]);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule